// File: doc/BRIEF.md
# Frame-Paced Rotary Encoder Step Decoder

This block turns a two-phase rotary encoder (already debounced off-chip) into single up or down steps on an 8-bit coarse delay value. The pins are not watched on every clock. A frame-paced down-counter opens a sample point once every `SAMPLE_FRAMES` audio frames, and the encoder is read only at those points.

At a sample point, a falling level on phase A with the edge marker still clear produces one step. Phase B sets the direction, and the marker is then set. While A stays low, later sample points do nothing. A high reading on A clears the marker and re-arms the decoder. Each step moves the coarse delay byte by one, which is 256 samples of delay. The byte is meant to feed a delay-line address generator as its high byte.

Top module: `enc_step_decoder`

## Requirements
- R1: After reset, `delay_hi_o` is 0.
- R2: The encoder is sampled only on every `SAMPLE_FRAMES`-th `frame_i` pulse after reset, counting pulses. Pin changes between sample points have no effect, and `delay_hi_o` changes only on the clock edge that takes a sampling frame pulse.
- R3: If phase A reads high (1) at a sample point, the edge marker is cleared and no step is taken.
- R4: If phase A reads low (0) at a sample point and the edge marker is set, no step is taken. A low period of A that spans many sample points gives at most one step.
- R5: If phase A reads low at a sample point and the edge marker is clear, exactly one step is taken and the marker is set.
- R6: On a step with phase B low (0), `delay_hi_o` increases by one.
- R7: On a step with phase B high (1), `delay_hi_o` decreases by one.
- R8: `delay_hi_o` wraps modulo 256, so 255 plus one gives 0 and 0 minus one gives 255.
- R9: The edge marker is set by reset. If A is low at the first sample point after reset, no step is taken.
- R10: Both encoder pins pass through a two-flop synchronizer. A pin change driven in the last clock cycle before a sampling edge is not seen at that sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-cycle audio frame strobe |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| delay_hi_o | output | 8 | Desired delay high byte |

## Verification
The bench builds the decoder with `SAMPLE_FRAMES` set to 4 and keeps the 8-bit delay width. The short sampling period brings several hundred sample points within a few thousand cycles. That is enough to drive the byte through both wrap boundaries with directed step sequences and to mix in random pin and frame patterns. A directed case changes phase A in the cycle just before a sampling edge, to show the synchronizer latency.

// File: rtl/enc_step_pkg.sv
package enc_step_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;  // idle encoder reads high
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/enc_frame_div.sv
module enc_frame_div #(
  parameter int SAMPLE_FRAMES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(SAMPLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(SAMPLE_FRAMES);
  localparam logic [CNT_W-1:0] LAST_V   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = frame_i && (cnt_q == LAST_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RELOAD_V;
    else if (tick_o) cnt_q <= RELOAD_V;
    else if (frame_i) cnt_q <= cnt_q - LAST_V;
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && (cnt_q <= RELOAD_V));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cnt_q));
endmodule

// File: rtl/enc_step_fsm.sv
module enc_step_fsm
  import enc_step_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  a_i,
  input  logic  b_i,
  output step_e step_o
);
  logic handled_q;  // current low period of A already produced its step

  always_comb begin
    step_o = STEP_NONE;
    if (tick_i && !a_i && !handled_q) step_o = b_i ? STEP_DN : STEP_UP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) handled_q <= 1'b1;
    else if (tick_i) handled_q <= !a_i;
  end

  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o != STEP_NONE) |=> (step_o == STEP_NONE));
  assert_high_rearms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && a_i) |-> (step_o == STEP_NONE));
endmodule

// File: rtl/enc_delay_acc.sv
module enc_delay_acc
  import enc_step_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  step_e        step_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_o <= '0;
    else begin
      unique case (step_i)
        STEP_UP: value_o <= value_o + ONE;  // wraps modulo 2**W
        STEP_DN: value_o <= value_o - ONE;
        default: value_o <= value_o;
      endcase
    end
  end
endmodule

// File: rtl/enc_step_decoder.sv
module enc_step_decoder
  import enc_step_pkg::*;
#(
  parameter int SAMPLE_FRAMES = 64,
  parameter int SYNC_STAGES   = 2,
  parameter int DELAY_W       = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic               enc_a_i,
  input  logic               enc_b_i,
  output logic [DELAY_W-1:0] delay_hi_o
);
  logic [1:0] pins_s;
  logic       tick;
  step_e      step;

  enc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({enc_b_i, enc_a_i}), .q_o(pins_s)
  );

  enc_frame_div #(.SAMPLE_FRAMES(SAMPLE_FRAMES)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .tick_o(tick)
  );

  enc_step_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .a_i(pins_s[0]), .b_i(pins_s[1]), .step_o(step)
  );

  enc_delay_acc #(.W(DELAY_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .value_o(delay_hi_o)
  );

  assert_step_needs_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step != STEP_NONE) |-> frame_i);
  assert_hold_without_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == STEP_NONE) |=> $stable(delay_hi_o));
  assert_up_by_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == STEP_UP) |=> (delay_hi_o == DELAY_W'($past(delay_hi_o) + 1'b1)));
  assert_down_by_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == STEP_DN) |=> (delay_hi_o == DELAY_W'($past(delay_hi_o) - 1'b1)));
endmodule

// File: tb/enc_step_decoder_tb.sv
module enc_step_decoder_tb;
  localparam int FR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic       enc_a = 1'b1;
  logic       enc_b = 1'b1;
  logic [7:0] delay_hi;

  int vectors = 0;
  int fails = 0;
  int cnt_m = FR;
  bit flag_m = 1'b1;
  bit a_m = 1'b1;
  bit b_m = 1'b1;
  logic [7:0] d_m = 8'd0;

  always #10 clk = ~clk;

  enc_step_decoder #(.SAMPLE_FRAMES(FR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .delay_hi_o(delay_hi)
  );

  function automatic logic [7:0] step_val(logic [7:0] d, bit b);
    return b ? d - 8'd1 : d + 8'd1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: delay_hi_o=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_pins(bit a, bit b);
    @(negedge clk);
    enc_a = a; enc_b = b; a_m = a; b_m = b;
    repeat (4) @(negedge clk);
  endtask

  // model update for one frame pulse using the settled pin levels a_m/b_m
  task automatic model_frame();
    cnt_m--;
    if (cnt_m == 0) begin
      cnt_m = FR;
      if (a_m) flag_m = 1'b0;
      else if (!flag_m) begin
        flag_m = 1'b1;
        d_m = step_val(d_m, b_m);
      end
    end
  endtask

  task automatic frame_pulse(string tag);
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
    model_frame();
    check(tag, delay_hi, d_m);
  endtask

  task automatic to_sample(string tag);
    for (int i = cnt_m; i > 0; i--) frame_pulse(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    enc_a = 1'b0; a_m = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset value", delay_hi, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", delay_hi, 8'd0);

    // R9: A low at first sample after reset gives no step
    to_sample("R9 no step on first low");
    check("R9 held zero", delay_hi, 8'd0);

    // R3 rearm, then R7/R8 down-wrap from 0
    set_pins(1, 1);
    to_sample("R3 high clears marker");
    set_pins(0, 1);
    to_sample("R7 R8 down wrap to 255");
    check("R8 wrap value", delay_hi, 8'd255);

    // R4: A stays low across many samples
    for (int k = 0; k < 3; k++) to_sample("R4 held low no step");
    check("R4 still 255", delay_hi, 8'd255);

    // R2: pin toggles between sample points have no effect
    set_pins(1, 0);
    frame_pulse("R2 mid-period frame");
    set_pins(0, 0);
    frame_pulse("R2 mid-period frame");
    set_pins(1, 0);
    to_sample("R2 only sample point counts");
    check("R2 no step from toggles", delay_hi, 8'd255);

    // R6/R8: up-wrap to 0, then further up steps
    for (int k = 0; k < 260; k++) begin
      set_pins(0, 0);
      to_sample("R5 R6 up step");
      set_pins(1, 0);
      to_sample("R3 rearm");
    end
    check("R8 up wrap result", delay_hi, 8'd3);

    // R10: A falls in the last cycle before a sampling edge; not seen
    while (cnt_m != 1) frame_pulse("R10 align");
    @(negedge clk); frame = 1'b1; enc_a = 1'b0; enc_b = 1'b0;
    @(negedge clk); frame = 1'b0;
    model_frame();
    check("R10 late change not sampled", delay_hi, d_m);
    a_m = 1'b0; b_m = 1'b0;
    repeat (4) @(negedge clk);
    to_sample("R10 seen at next sample");
    check("R10 step at next sample", delay_hi, 8'd4);

    // random mix
    for (int k = 0; k < 1500; k++) begin
      if ($urandom_range(0, 1) == 1) set_pins(1'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 3)) @(negedge clk);
      frame_pulse("R2-R8 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule